// File: doc/BRIEF.md
# Memory Init and Patrol Scrubber

This block is a memory bus master that maintains check bits in ECC-protected memory. A start pulse launches an initialisation pass that writes a fixed fill word once to every word of the protected regions, so that every location holds a valid code word before normal traffic uses it. After that, a level enable keeps the block walking the same regions in a loop. Each word is read through the external ECC checker. When the checker reports a corrected single-bit error, the corrected word is written back to repair the stored copy before a second flip can make it uncorrectable.

Up to `NREG` protected regions are described by inclusive start and exclusive end addresses. Up to `NEXC` exclusion ranges punch holes in them. The memory port uses a request/grant handshake, so normal traffic can hold the scrubber off. A programmable gap between patrol reads limits how much bandwidth the scan takes. The ECC encoder and decoder and the memory itself sit outside the block.

Top module: `mem_scrubber`

## Requirements
- R1: After a `start_init` pulse in idle, the block writes `FILL_WORD` exactly once to every word `a` with `lo <= a < hi` of some protected region. It issues no read during this pass.
- R2: A region whose start is equal to or above its end is empty and gets no access. The walk moves on to the next region in index order.
- R3: A word with `skip_lo <= a < skip_hi` of any non-empty exclusion range (start below end) gets no access, in either mode. Overlapping exclusions combine.
- R4: `init_done` rises after the last initialisation write and stays high until the next `start_init`. That pulse clears it on the following cycle.
- R5: While `patrol_en` is high and no initialisation is running, the block reads the valid words in ascending order, region by region. After the last word of the last region it wraps to the first valid word.
- R6: When a patrol read returns `mem_sbe` high, the block writes the returned `mem_rdata` back to the same address before it issues the next read. Patrol issues no other writes.
- R7: When a patrol read returns `mem_dbe` high, the block does not write that word. It pulses `ue_valid` for one cycle with `ue_addr` equal to the word's address, and the scan continues with the next word.
- R8: Between consecutive patrol reads the block inserts `scan_gap` extra idle cycles. Raising `scan_gap` by N lengthens the read-to-read spacing by exactly N cycles.
- R9: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. A command is accepted only in a cycle with both `mem_req` and `mem_gnt` high, and a read returns `mem_rvalid` in a later cycle.
- R10: While `rst` is asserted and in the first cycle after it, `mem_req`, `init_done` and `ue_valid` are low.
- R11: With `patrol_en` low and no initialisation pass running, the block issues no memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_init | input | 1 | Pulse in idle: begin the initialisation pass |
| patrol_en | input | 1 | Level: run the continuous patrol scan |
| scan_gap | input | IVW | Extra idle cycles between patrol reads |
| ecc_lo | input | NREG*AW | Region start addresses, region i at bits [i*AW +: AW] |
| ecc_hi | input | NREG*AW | Region exclusive end addresses, same packing |
| skip_lo | input | NEXC*AW | Exclusion range starts, range k at bits [k*AW +: AW] |
| skip_hi | input | NEXC*AW | Exclusion range exclusive ends, same packing |
| mem_req | output | 1 | Memory command request |
| mem_gnt | input | 1 | Memory command grant |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DW | Read data after correction |
| mem_sbe | input | 1 | Response carried a corrected single-bit error |
| mem_dbe | input | 1 | Response carried an uncorrectable error |
| init_done | output | 1 | Initialisation pass finished |
| ue_valid | output | 1 | One-cycle pulse: uncorrectable error seen |
| ue_addr | output | AW | Address of the uncorrectable word |

## Verification
Several rules are checked on every cycle:
- The command and its address stay stable while the grant is withheld.
- The initialisation pass never issues a read.
- Patrol writes happen only after a response flagged as corrected.
- An uncorrectable response never leads to a write and always produces the error pulse.
- The done flag stays high until the next start.
- Reset leaves the port quiet.

Other properties need a whole pass to show. These are covering each word exactly once, skipping empty regions and overlapping exclusions, the wrap order of the patrol, the repaired memory contents, and the exact cycle cost of the read gap. The bench's scenarios against a memory model show them.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_WRITE,
        ST_GAP,
        ST_READ,
        ST_RWAIT,
        ST_FIX
    } scrub_state_e;

    typedef enum logic {
        MODE_INIT,
        MODE_PATROL
    } scrub_mode_e;

    typedef enum logic [1:0] {
        LOC_VALID,
        LOC_NEXT_REGION,
        LOC_JUMP
    } loc_kind_e;

    typedef struct packed {
        logic      pass_end;
        loc_kind_e kind;
    } loc_info_t;

    function automatic logic in_window(input logic [63:0] a,
                                       input logic [63:0] lo,
                                       input logic [63:0] hi);
        return (lo < hi) && (a >= lo) && (a < hi);
    endfunction

endpackage

// File: rtl/scrub_locator.sv
module scrub_locator
    import scrub_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 5,
    parameter int NEXC = 5,
    parameter int IW   = $clog2(NREG + 1)
) (
    input  logic [IW-1:0]      reg_idx,
    input  logic [AW-1:0]      cur_addr,
    input  logic [NREG*AW-1:0] ecc_lo,
    input  logic [NREG*AW-1:0] ecc_hi,
    input  logic [NEXC*AW-1:0] skip_lo,
    input  logic [NEXC*AW-1:0] skip_hi,
    output loc_info_t          info,
    output logic [AW-1:0]      jump_addr,
    output logic [IW-1:0]      next_idx
);
    localparam int SLOTS = 2 ** IW;

    logic [AW-1:0] lo_tab [SLOTS];
    logic [AW-1:0] hi_tab [SLOTS];
    logic [AW-1:0] xe_tab [NEXC];
    logic [NEXC-1:0] hit;

    for (genvar i = 0; i < SLOTS; i++) begin : g_reg
        if (i < NREG) begin : g_live
            assign lo_tab[i] = ecc_lo[i*AW +: AW];
            assign hi_tab[i] = ecc_hi[i*AW +: AW];
        end else begin : g_pad
            assign lo_tab[i] = '0;
            assign hi_tab[i] = '0;
        end
    end

    for (genvar k = 0; k < NEXC; k++) begin : g_exc
        assign xe_tab[k] = skip_hi[k*AW +: AW];
        assign hit[k] = in_window(64'(cur_addr), 64'(skip_lo[k*AW +: AW]),
                                  64'(skip_hi[k*AW +: AW]));
    end

    logic [IW-1:0] idx_inc;
    assign idx_inc = reg_idx + IW'(1);

    always_comb begin
        info.pass_end = 1'b0;
        info.kind     = LOC_VALID;
        jump_addr     = cur_addr;
        next_idx      = reg_idx;
        if (int'(reg_idx) >= NREG) begin
            info.pass_end = 1'b1;
            info.kind     = LOC_NEXT_REGION;
        end else if (!in_window(64'(cur_addr), 64'(lo_tab[reg_idx]),
                                64'(hi_tab[reg_idx]))) begin
            info.kind = LOC_NEXT_REGION;
            next_idx  = idx_inc;
            jump_addr = lo_tab[idx_inc];
        end else if (|hit) begin
            info.kind = LOC_JUMP;
            for (int k = NEXC - 1; k >= 0; k--) begin
                if (hit[k]) jump_addr = xe_tab[k];
            end
        end
    end

endmodule

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
    parameter int IVW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [IVW-1:0] interval,
    output logic           expired
);
    logic [IVW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= interval;
        end else if (cnt != '0) begin
            cnt <= cnt - IVW'(1);
        end
    end

    assign expired = (cnt == '0) && !load;

endmodule

// File: rtl/mem_scrubber.sv
module mem_scrubber
    import scrub_pkg::*;
#(
    parameter int             AW        = 16,
    parameter int             DW        = 32,
    parameter int             NREG      = 5,
    parameter int             NEXC      = 5,
    parameter int             IVW       = 8,
    parameter logic [DW-1:0]  FILL_WORD = DW'(32'h5A5A_C3C3)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_init,
    input  logic               patrol_en,
    input  logic [IVW-1:0]     scan_gap,
    input  logic [NREG*AW-1:0] ecc_lo,
    input  logic [NREG*AW-1:0] ecc_hi,
    input  logic [NEXC*AW-1:0] skip_lo,
    input  logic [NEXC*AW-1:0] skip_hi,
    output logic               mem_req,
    input  logic               mem_gnt,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic               mem_rvalid,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_sbe,
    input  logic               mem_dbe,
    output logic               init_done,
    output logic               ue_valid,
    output logic [AW-1:0]      ue_addr
);
    localparam int IW = $clog2(NREG + 1);

    scrub_state_e  state;
    scrub_mode_e   mode;
    logic [IW-1:0] reg_idx;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] fix_data;

    loc_info_t     loc;
    logic [AW-1:0] loc_jump;
    logic [IW-1:0] loc_next;
    logic          pace_load;
    logic          pace_done;
    logic          init_busy;

    scrub_locator #(
        .AW(AW), .NREG(NREG), .NEXC(NEXC), .IW(IW)
    ) u_loc (
        .reg_idx  (reg_idx),
        .cur_addr (cur_addr),
        .ecc_lo   (ecc_lo),
        .ecc_hi   (ecc_hi),
        .skip_lo  (skip_lo),
        .skip_hi  (skip_hi),
        .info     (loc),
        .jump_addr(loc_jump),
        .next_idx (loc_next)
    );

    assign pace_load = (state == ST_SEEK) && !loc.pass_end &&
                       (loc.kind == LOC_VALID) && (mode == MODE_PATROL) &&
                       patrol_en;

    scrub_pacer #(.IVW(IVW)) u_pace (
        .clk     (clk),
        .rst     (rst),
        .load    (pace_load),
        .interval(scan_gap),
        .expired (pace_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mode      <= MODE_INIT;
            reg_idx   <= '0;
            cur_addr  <= '0;
            fix_data  <= '0;
            init_done <= 1'b0;
            ue_valid  <= 1'b0;
            ue_addr   <= '0;
        end else begin
            ue_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_init) begin
                        mode      <= MODE_INIT;
                        init_done <= 1'b0;
                        reg_idx   <= '0;
                        cur_addr  <= ecc_lo[AW-1:0];
                        state     <= ST_SEEK;
                    end else if (patrol_en) begin
                        mode     <= MODE_PATROL;
                        reg_idx  <= '0;
                        cur_addr <= ecc_lo[AW-1:0];
                        state    <= ST_SEEK;
                    end
                end
                ST_SEEK: begin
                    if (loc.pass_end) begin
                        reg_idx  <= '0;
                        cur_addr <= ecc_lo[AW-1:0];
                        if (mode == MODE_INIT) begin
                            init_done <= 1'b1;
                            state     <= ST_IDLE;
                        end else if (!patrol_en) begin
                            state <= ST_IDLE;
                        end
                    end else if (mode == MODE_PATROL && !patrol_en) begin
                        state <= ST_IDLE;
                    end else begin
                        unique case (loc.kind)
                            LOC_NEXT_REGION: begin
                                reg_idx  <= loc_next;
                                cur_addr <= loc_jump;
                            end
                            LOC_JUMP: cur_addr <= loc_jump;
                            default: state <= (mode == MODE_INIT) ? ST_WRITE : ST_GAP;
                        endcase
                    end
                end
                ST_WRITE: begin
                    if (mem_gnt) begin
                        cur_addr <= cur_addr + AW'(1);
                        state    <= ST_SEEK;
                    end
                end
                ST_GAP: begin
                    if (pace_done) state <= ST_READ;
                end
                ST_READ: begin
                    if (mem_gnt) state <= ST_RWAIT;
                end
                ST_RWAIT: begin
                    if (mem_rvalid) begin
                        if (mem_sbe && !mem_dbe) begin
                            fix_data <= mem_rdata;
                            state    <= ST_FIX;
                        end else begin
                            if (mem_dbe) begin
                                ue_valid <= 1'b1;
                                ue_addr  <= cur_addr;
                            end
                            cur_addr <= cur_addr + AW'(1);
                            state    <= ST_SEEK;
                        end
                    end
                end
                ST_FIX: begin
                    if (mem_gnt) begin
                        cur_addr <= cur_addr + AW'(1);
                        state    <= ST_SEEK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == ST_WRITE) || (state == ST_READ) || (state == ST_FIX);
    assign mem_we    = (state == ST_WRITE) || (state == ST_FIX);
    assign mem_addr  = cur_addr;
    assign mem_wdata = (state == ST_FIX) ? fix_data : FILL_WORD;
    assign init_busy = (mode == MODE_INIT) && (state != ST_IDLE);

endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start_init,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_rvalid,
    input logic          mem_sbe,
    input logic          mem_dbe,
    input logic          init_done,
    input logic          ue_valid,
    input logic          init_busy
);
    logic fix_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            fix_armed <= 1'b0;
        end else if (mem_rvalid && mem_sbe && !mem_dbe && !init_busy) begin
            fix_armed <= 1'b1;
        end else if (mem_req && mem_gnt && mem_we) begin
            fix_armed <= 1'b0;
        end
    end

    // R9
    hold_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R1
    init_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && init_busy) |-> mem_we);

    // R6
    fix_after_sbe_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !init_busy) |-> fix_armed);

    // R7
    ue_after_dbe_chk: assert property (@(posedge clk) disable iff (rst)
        ue_valid |-> $past(mem_rvalid && mem_dbe));

    // R7
    no_fix_on_dbe_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rvalid && mem_dbe && !init_busy) |=> !mem_req);

    // R4
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && !start_init) |=> init_done);

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req && !ue_valid && !init_done));

endmodule

bind mem_scrubber scrub_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_init(start_init),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rvalid(mem_rvalid),
    .mem_sbe   (mem_sbe),
    .mem_dbe   (mem_dbe),
    .init_done (init_done),
    .ue_valid  (ue_valid),
    .init_busy (init_busy)
);

// File: tb/tb_mem_scrubber.sv
module tb_mem_scrubber;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NREG = 5;
    localparam int NEXC = 5;
    localparam int IVW = 8;
    localparam logic [DW-1:0] FILL = 32'h5A5A_C3C3;
    localparam int WORDS = 256;

    typedef struct packed {
        logic [7:0] r0s, r0e, r1s, r1e, r2s, r2e, x0s, x0e, x1s, x1e;
    } vec_t;

    // r0 | r1 | r2 | x0 | x1 ; exp writes noted
    localparam vec_t VECS [5] = '{
        '{8'h10, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, // 16
        '{8'h00, 8'h08, 8'h08, 8'h08, 8'h30, 8'h38, 8'h02, 8'h04, 8'h00, 8'h00}, // 14, empty r1 (R2)
        '{8'h40, 8'h50, 8'h60, 8'h64, 8'h00, 8'h00, 8'h44, 8'h48, 8'h46, 8'h4C}, // 12, overlap (R3)
        '{8'h20, 8'h20, 8'h80, 8'h84, 8'h90, 8'h92, 8'h80, 8'h84, 8'h00, 8'h00}, // 2
        '{8'h10, 8'h18, 8'h18, 8'h1A, 8'h00, 8'h00, 8'h15, 8'h12, 8'h00, 8'h00}  // 10, reversed excl
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_init = 1'b0;
    logic patrol_en = 1'b0;
    logic [IVW-1:0] scan_gap = '0;
    logic [NREG*AW-1:0] ecc_lo = '0, ecc_hi = '0;
    logic [NEXC*AW-1:0] skip_lo = '0, skip_hi = '0;
    logic mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr, ue_addr;
    logic [DW-1:0] mem_wdata;
    logic mem_rvalid = 1'b0, mem_sbe = 1'b0, mem_dbe = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic init_done, ue_valid;
    logic gnt_en = 1'b1;

    always #10 clk = ~clk;
    assign mem_gnt = gnt_en;

    mem_scrubber #(
        .AW(AW), .DW(DW), .NREG(NREG), .NEXC(NEXC), .IVW(IVW), .FILL_WORD(FILL)
    ) dut (
        .clk(clk), .rst(rst), .start_init(start_init), .patrol_en(patrol_en),
        .scan_gap(scan_gap), .ecc_lo(ecc_lo), .ecc_hi(ecc_hi),
        .skip_lo(skip_lo), .skip_hi(skip_hi), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_sbe(mem_sbe),
        .mem_dbe(mem_dbe), .init_done(init_done), .ue_valid(ue_valid), .ue_addr(ue_addr)
    );

    // memory model and logs
    logic [DW-1:0] mem [WORDS];
    logic sbe_f [WORDS];
    logic dbe_f [WORDS];
    logic [DW-1:0] cval [WORDS];
    int wr_cnt [WORDS];
    int rd_cnt [WORDS];
    int rd_seq [64];
    int rd_time [64];
    int rd_n, wr_n, ue_cnt, req_cycles, cyc;
    logic [AW-1:0] ue_last;
    logic clr_log = 1'b0;
    logic inj_go = 1'b0;
    logic [1:0] inj_kind = '0;
    logic [AW-1:0] inj_addr = '0;
    logic [DW-1:0] inj_val = '0;

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = '0; sbe_f[i] = 1'b0; dbe_f[i] = 1'b0; cval[i] = '0;
            wr_cnt[i] = 0; rd_cnt[i] = 0;
        end
        rd_n = 0; wr_n = 0; ue_cnt = 0; req_cycles = 0; cyc = 0; ue_last = '0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rvalid <= 1'b0;
        mem_sbe <= 1'b0;
        mem_dbe <= 1'b0;
        if (clr_log) begin
            for (int i = 0; i < WORDS; i++) begin
                wr_cnt[i] <= 0; rd_cnt[i] <= 0;
            end
            rd_n <= 0; wr_n <= 0; ue_cnt <= 0; req_cycles <= 0;
        end else begin
            if (mem_req) req_cycles <= req_cycles + 1;
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    sbe_f[mem_addr] <= 1'b0;
                    wr_cnt[mem_addr] <= wr_cnt[mem_addr] + 1;
                    wr_n <= wr_n + 1;
                end else begin
                    mem_rvalid <= 1'b1;
                    mem_rdata <= sbe_f[mem_addr] ? cval[mem_addr] : mem[mem_addr];
                    mem_sbe <= sbe_f[mem_addr];
                    mem_dbe <= dbe_f[mem_addr];
                    rd_cnt[mem_addr] <= rd_cnt[mem_addr] + 1;
                    if (rd_n < 64) begin
                        rd_seq[rd_n] <= int'(mem_addr);
                        rd_time[rd_n] <= cyc;
                    end
                    rd_n <= rd_n + 1;
                end
            end
            if (ue_valid) begin
                ue_cnt <= ue_cnt + 1;
                ue_last <= ue_addr;
            end
        end
        if (inj_go) begin
            sbe_f[inj_addr] <= (inj_kind == 2'd1);
            dbe_f[inj_addr] <= (inj_kind == 2'd2);
            cval[inj_addr] <= inj_val;
        end
    end

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_logs();
        clr_log = 1'b1; cycles(1); clr_log = 1'b0;
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [1:0] k, input logic [DW-1:0] v);
        inj_addr = a; inj_kind = k; inj_val = v; inj_go = 1'b1;
        cycles(1);
        inj_go = 1'b0;
    endtask

    task automatic apply_vec(input vec_t v);
        ecc_lo = {8'h00, 8'h00, v.r2s, v.r1s, v.r0s};
        ecc_hi = {8'h00, 8'h00, v.r2e, v.r1e, v.r0e};
        skip_lo = {8'h00, 8'h00, 8'h00, v.x1s, v.x0s};
        skip_hi = {8'h00, 8'h00, 8'h00, v.x1e, v.x0e};
    endtask

    function automatic bit inwin(input int a, input int lo, input int hi);
        return lo < hi && a >= lo && a < hi;
    endfunction

    function automatic bit expect_hit(input vec_t v, input int a);
        bit r;
        r = inwin(a, v.r0s, v.r0e) || inwin(a, v.r1s, v.r1e) || inwin(a, v.r2s, v.r2e);
        return r && !inwin(a, v.x0s, v.x0e) && !inwin(a, v.x1s, v.x1e);
    endfunction

    task automatic run_init();
        start_init = 1'b1; cycles(1); start_init = 1'b0;
        for (int t = 0; t < 3000; t++) begin
            if (init_done) break;
            cycles(1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int d0, d1, d3, miss, stray, badfill, a1, seq_bad;
        cycles(3);
        // R10 during reset
        chk(!mem_req && !init_done && !ue_valid, "R10 quiet in reset",
            {mem_req, init_done, ue_valid}, 0);
        rst = 1'b0;
        cycles(1);
        chk(!mem_req && !init_done && !ue_valid, "R10 quiet after reset",
            {mem_req, init_done, ue_valid}, 0);

        // R11: nothing requested when idle
        apply_vec(VECS[0]);
        clear_logs();
        cycles(30);
        chk(req_cycles == 0, "R11 idle no requests", req_cycles, 0);

        // table walk: R1, R2, R3, R4
        for (int v = 0; v < 5; v++) begin
            apply_vec(VECS[v]);
            clear_logs();
            run_init();
            chk(init_done, "R4 done after init pass", init_done, 1);
            cycles(10);
            miss = 0; stray = 0; badfill = 0;
            for (int a = 0; a < WORDS; a++) begin
                if (expect_hit(VECS[v], a)) begin
                    if (wr_cnt[a] != 1) miss++;
                    if (mem[a] != FILL) badfill++;
                end else if (wr_cnt[a] != 0 || rd_cnt[a] != 0) begin
                    stray++;
                end
            end
            chk(miss == 0, "R1 each word written once", miss, 0);
            chk(badfill == 0, "R1 fill word stored", badfill, 0);
            chk(stray == 0, "R2/R3 no access outside valid words", stray, 0);
            chk(rd_n == 0, "R1 no reads during init", rd_n, 0);
            chk(init_done && !mem_req, "R4 done holds, port idle", {init_done, mem_req}, 2);
        end

        // R4: start clears done
        start_init = 1'b1; cycles(1); start_init = 1'b0;
        chk(!init_done, "R4 start clears done", init_done, 0);
        for (int t = 0; t < 3000; t++) begin
            if (init_done) break;
            cycles(1);
        end

        // patrol: R5, R6, R7 on region [0,16)
        ecc_lo = '0; ecc_hi = {8'h00, 8'h00, 8'h00, 8'h00, 8'h10};
        skip_lo = '0; skip_hi = '0;
        run_init();
        inject(8'd5, 2'd1, 32'h1234_5678);
        inject(8'd9, 2'd2, 32'h0);
        clear_logs();
        scan_gap = 8'd0;
        patrol_en = 1'b1;
        cycles(220);
        patrol_en = 1'b0;
        cycles(30);
        seq_bad = 0;
        for (int i = 0; i < 24; i++) if (rd_seq[i] != (i % 16)) seq_bad++;
        chk(rd_n >= 24 && seq_bad == 0, "R5 ascending order with wrap", seq_bad, 0);
        chk(mem[5] == 32'h1234_5678, "R6 corrected word written back", mem[5], 32'h1234_5678);
        chk(wr_cnt[5] == 1 && wr_n == 1, "R6 single repair write", wr_n, 1);
        chk(wr_cnt[9] == 0, "R7 no write to uncorrectable word", wr_cnt[9], 0);
        chk(ue_cnt >= 2 && ue_last == 8'd9, "R7 error pulse with address", ue_last, 9);
        chk(rd_cnt[10] >= 2, "R7 scan continues past error", rd_cnt[10], 2);
        chk(!mem_req, "R11 stops after enable drops", mem_req, 0);

        // R8: read spacing grows by scan_gap
        inject(8'd9, 2'd0, 32'h0);
        ecc_lo = {8'h00, 8'h00, 8'h00, 8'h00, 8'h40};
        ecc_hi = {8'h00, 8'h00, 8'h00, 8'h00, 8'h48};
        scan_gap = 8'd0; clear_logs(); patrol_en = 1'b1; cycles(60); patrol_en = 1'b0; cycles(30);
        d0 = rd_time[2] - rd_time[1];
        scan_gap = 8'd10; clear_logs(); patrol_en = 1'b1; cycles(100); patrol_en = 1'b0; cycles(30);
        d1 = rd_time[2] - rd_time[1];
        chk(d1 - d0 == 10, "R8 gap of 10 adds 10 cycles", d1 - d0, 10);
        scan_gap = 8'd3; clear_logs(); patrol_en = 1'b1; cycles(80); patrol_en = 1'b0; cycles(30);
        d3 = rd_time[2] - rd_time[1];
        chk(d3 - d0 == 3, "R8 gap of 3 adds 3 cycles", d3 - d0, 3);

        // R9: hold while grant withheld
        scan_gap = 8'd0;
        gnt_en = 1'b0;
        clear_logs();
        patrol_en = 1'b1;
        cycles(20);
        chk(mem_req, "R9 request raised", mem_req, 1);
        a1 = int'(mem_addr);
        cycles(7);
        chk(mem_req && int'(mem_addr) == a1, "R9 address held", mem_addr, a1);
        chk(rd_n == 0, "R9 nothing accepted without grant", rd_n, 0);
        gnt_en = 1'b1;
        cycles(10);
        chk(rd_n > 0 && rd_seq[0] == a1, "R9 held command accepted", rd_seq[0], a1);
        patrol_en = 1'b0;
        cycles(30);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule